// File: doc/BRIEF.md
# Fractional Clock Rate Controller with Kick-Commit

This block produces a clock-enable stream whose average rate is a fraction of its parent clock. The parent clock is split into frames of 32 cycles. In each frame the block lets through a programmed number of enable pulses and swallows the rest. A phase accumulator spreads the pulses evenly across the frame. The effective multiplier is (32 − code) / 32. The 5-bit code runs from 0, which gives every cycle, to 31, which gives one cycle in 32.

Software programs the code through a small memory-mapped register port. Writing the code only stages it. The new ratio takes effect after software sets a commit bit in a second register. That bit reads as 1 while the change is pending. Hardware clears it on the frame boundary where the staged code becomes active. While the commit is pending, the staged code is locked, and software must wait for the bit to clear before it starts another change.

The enable output is a plain level sampled by downstream logic. It has no handshake and no back-pressure. The register port is a single-cycle write strobe with a combinational read path.

Top module: `zrate_ctrl`

## Requirements
- R1: After reset, both registers read 0, no commit is pending, and the active code is 0, so `clk_en` is high on all 32 cycles of any 32-cycle window.
- R2: With a stable active code Z, every window of 32 consecutive cycles holds exactly 32 − Z enable pulses. Z = 0 gives 32 pulses and Z = 31 gives 1 pulse.
- R3: A write to the rate register (offset 0xE0) stages the code in bits 12:8 and reads it back. The enable rate does not change until a commit completes.
- R4: Writing 1 to bit 31 of the commit register (offset 0x04) starts a commit. Bit 31 then reads 1 until hardware clears it.
- R5: A pending commit completes on the next 32-cycle frame boundary. The active code takes the staged value and bit 31 clears on that same edge, no later than 32 cycles after the commit write.
- R6: While a commit is pending, writes to bits 12:8 of the rate register are ignored. The readback and the committed rate both keep the earlier staged code.
- R7: All bits of the rate register outside 12:8, and bits 30:0 of the commit register, read back as last written. This holds even while a commit is pending.
- R8: Writing 0 to bit 31 of the commit register while a commit is pending does not cancel the commit.
- R9: When the multiplier 32 − Z is 16 or less, two enable pulses never fall on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, captured on the rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| clk_en | output | 1 | Registered enable pulse stream |

## Verification
The bench drives inputs on the falling edge. Register writes land on the next rising edge, and reads are combinational, so they are sampled one time step after the address changes. A commit completes on a frame boundary up to 32 rising edges after the write edge. The bench therefore polls bit 31 once per cycle, checks that it clears within that bound, and only then lets a further cycle pass. `clk_en` is registered and lags the accumulator by one cycle, so rate checks count pulses over a full 32-cycle window that starts after the new code is in force. Because the pattern repeats every 32 cycles, the count does not depend on how the window lines up with the frame.

// File: rtl/zr_pkg.sv
package zr_pkg;
  localparam int FRAC_W    = 5;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int FIELD_LSB = 8;
  localparam int KICK_BIT  = 31;
  localparam logic [7:0] RATE_OFS = 8'hE0;
  localparam logic [7:0] KICK_OFS = 8'h04;
endpackage

// File: rtl/zr_frame.sv
module zr_frame #(
  parameter int FRAC_W = zr_pkg::FRAC_W
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_start,
  output logic frame_end
);
  logic [FRAC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  assign frame_start = (phase_q == '0);
  assign frame_end   = (phase_q == '1);

  // R5
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_start);
endmodule

// File: rtl/zr_regs.sv
module zr_regs #(
  parameter int ADDR_W = zr_pkg::ADDR_W,
  parameter int DATA_W = zr_pkg::DATA_W,
  parameter int FRAC_W = zr_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_end,
  output logic [DATA_W-1:0] rdata,
  output logic [FRAC_W-1:0] zfc_active
);
  import zr_pkg::*;

  localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(RATE_OFS);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(KICK_OFS);

  logic [DATA_W-1:0] rate_q, rate_nxt;
  logic [DATA_W-1:0] kword_q;
  logic              kick_q;
  logic [FRAC_W-1:0] staged;
  logic              commit;
  logic              wr_rate, wr_kick;

  assign staged  = rate_q[FIELD_LSB +: FRAC_W];
  assign commit  = kick_q && frame_end;
  assign wr_rate = wr_en && (addr == A_RATE);
  assign wr_kick = wr_en && (addr == A_KICK);

  always_comb begin
    rate_nxt = wdata;
    if (kick_q) rate_nxt[FIELD_LSB +: FRAC_W] = staged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q     <= '0;
      kword_q    <= '0;
      kick_q     <= 1'b0;
      zfc_active <= '0;
    end else begin
      if (wr_rate) rate_q <= rate_nxt;
      if (wr_kick) begin
        kword_q           <= wdata;
        kword_q[KICK_BIT] <= 1'b0;
      end
      if (commit) begin
        kick_q     <= 1'b0;
        zfc_active <= staged;
      end else if (wr_kick && wdata[KICK_BIT]) begin
        kick_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_RATE) begin
      rdata = rate_q;
    end else if (addr == A_KICK) begin
      rdata           = kword_q;
      rdata[KICK_BIT] = kick_q;
    end
  end

  // R5
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && frame_end) |=> !kick_q);
  // R8
  kick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && !frame_end) |=> kick_q);
  // R6
  stage_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |=> $stable(staged));
  // R3
  active_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zfc_active) |-> $past(kick_q && frame_end));
endmodule

// File: rtl/zr_swallow.sv
module zr_swallow #(
  parameter int FRAC_W = zr_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] zfc_active,
  input  logic              frame_start,
  output logic              en_q
);
  localparam int FRAME = 1 << FRAC_W;
  localparam int HALF  = FRAME / 2;

  logic [FRAC_W:0]   mult;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_q;
  logic              pulse_nxt;

  assign mult      = (FRAC_W+1)'(FRAME) - {1'b0, zfc_active};
  assign sum       = {1'b0, acc_q} + mult;
  assign pulse_nxt = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      en_q  <= pulse_nxt;
    end
  end

  // R2
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (acc_q == '0));
  // R9
  spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_nxt && (mult <= (FRAC_W+1)'(HALF))) |=>
      (!pulse_nxt || (mult > (FRAC_W+1)'(HALF))));
endmodule

// File: rtl/zrate_ctrl.sv
module zrate_ctrl #(
  parameter int ADDR_W = zr_pkg::ADDR_W,
  parameter int DATA_W = zr_pkg::DATA_W,
  parameter int FRAC_W = zr_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_en
);
  logic              frame_start, frame_end;
  logic [FRAC_W-1:0] zfc_active;

  zr_frame #(.FRAC_W(FRAC_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  zr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .frame_end(frame_end),
    .rdata(bus_rdata), .zfc_active(zfc_active)
  );

  zr_swallow #(.FRAC_W(FRAC_W)) u_swallow (
    .clk(clk), .rst_n(rst_n), .zfc_active(zfc_active),
    .frame_start(frame_start), .en_q(clk_en)
  );
endmodule

// File: tb/tb_zrate_ctrl.sv
module tb_zrate_ctrl;
  localparam logic [7:0]  A_RATE = 8'hE0;
  localparam logic [7:0]  A_KICK = 8'h04;
  localparam logic [31:0] FMASK  = 32'h0000_1F00;
  localparam int NV = 6;
  localparam logic [4:0]  ZFC_TAB [NV] = '{5'd0, 5'd31, 5'd16, 5'd1, 5'd15, 5'd24};
  localparam logic [31:0] PAT_TAB [NV] = '{32'hA5A5_00FF, 32'h1234_E0C3,
    32'hFFFF_E0FF, 32'h0001_0001, 32'h8000_0000, 32'h5A5A_A05A};

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, clk_en;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  zrate_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic window(output int n, output bit adj);
    bit prev = 1'b0;
    n = 0; adj = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_en) begin n++; if (prev) adj = 1'b1; end
      prev = clk_en;
    end
  endtask

  task automatic wait_clear(output int cyc);
    logic [31:0] d;
    cyc = 0;
    rd(A_KICK, d);
    while (d[31] && cyc < 40) begin
      @(negedge clk); cyc++; rd(A_KICK, d);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, word;
    int n, cyc, cur;
    bit adj;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_RATE, d); check(d == 0, "R1 rate reg", d, 0);
    rd(A_KICK, d); check(d == 0, "R1 kick reg", d, 0);
    @(negedge clk);
    window(n, adj); check(n == 32, "R1 full rate", n, 32);

    cur = 32;
    for (int v = 0; v < NV; v++) begin
      word = (PAT_TAB[v] & ~FMASK) | ({27'd0, ZFC_TAB[v]} << 8);
      wr(A_RATE, word);
      rd(A_RATE, d); check(d == word, "R3/R7 staged readback", d, word);
      window(n, adj); check(n == cur, "R3 rate unchanged before commit", n, cur);
      wr(A_KICK, 32'h8000_0000);
      rd(A_KICK, d); check(d[31], "R4 kick pending", d[31], 1);
      wait_clear(cyc);
      check(cyc >= 1 && cyc <= 32, "R5 commit latency", cyc, 32);
      @(negedge clk);
      cur = 32 - int'(ZFC_TAB[v]);
      window(n, adj); check(n == cur, "R2 pulses per window", n, cur);
      if (cur <= 16) check(!adj, "R9 no adjacent pulses", adj, 0);
    end

    // R6 / R7 / R8 writes while pending
    wr(A_RATE, 32'h0000_0400);             // stage code 4
    wr(A_KICK, 32'h8000_0000);
    wr(A_RATE, 32'hC3C3_1B3C);             // code 27 must be ignored
    rd(A_RATE, d);
    check(d[12:8] == 5'd4, "R6 field locked", d[12:8], 4);
    check((d & ~FMASK) == (32'hC3C3_1B3C & ~FMASK), "R7 rate other bits", d, 32'hC3C3_043C);
    wr(A_KICK, 32'h0000_7E57);             // bit31 = 0 must not cancel
    rd(A_KICK, d);
    check(d[31], "R8 kick not cancelled", d[31], 1);
    check(d[30:0] == 31'h7E57, "R7 kick other bits", d[30:0], 31'h7E57);
    wait_clear(cyc); check(cyc <= 32, "R5 clears", cyc, 32);
    @(negedge clk);
    window(n, adj); check(n == 28, "R6 committed old stage", n, 28);
    rd(A_KICK, d); check(d == 32'h0000_7E57, "R7 kick reg after clear", d, 32'h7E57);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule